// File: doc/BRIEF.md
# Prescaled Interval Timer with Compare Match

This block is a single-channel timer on a simple same-clock register bus (address, write strobe, write data, combinational read data) with one level interrupt output. A clock prescaler feeds count ticks to an up-counter. Each tick is compared against a programmable compare value.

Software can leave the counter running freely as a wrapping time base. It can instead have the counter fall back to zero after it reaches the compare value, which gives periodic events. A one-shot event is made by stopping, clearing and restarting the counter around a single match. A match can raise a sticky status flag, which drives the interrupt pin until software clears it.

Stopping the counter normally only freezes it. It also clears the counter when the stop write carries the clear-enable bit, but only after the timer has once been started with that bit set.

Top module: `intv_timer`

## Requirements
- R1: A count tick occurs every clock cycle while running with prescaling off (control bit 2 = 0). With prescaling on, a tick occurs every 2^(n+1) cycles, where n is the divider register (offset 0x10, bits [DIV_W-1:0]). The first tick after a start comes 2^(n+1) cycles after the start write.
- R2: The control register is at offset 0x00, with run at bit 0, clear-enable at bit 1, prescale-enable at bit 2 and a mode field at bits [4:3] (interval mode is 0). The counter changes only while run is 1, and a stop write without a clear leaves its value frozen.
- R3: Once armed, a control write with run=0 and clear-enable=1 stops the counter and forces it to zero. The zero takes priority over a tick in the same cycle.
- R4: The block is armed by the first control write that has both run=1 and clear-enable=1, and it stays armed until reset. Before that, a control write with run=0 and clear-enable=1 only freezes the counter.
- R5: The match register is at offset 0x0C, with interrupt-enable at bit 0 and zero-clear at bit 1. With zero-clear on, the tick after the count equals the compare value returns the counter to zero. With zero-clear off, the counter wraps at 2^CNT_W.
- R6: With interrupt-enable on, the status flag (status bit 0, offset 0x04) is set at the same clock edge at which a tick makes the counter equal to the compare value. With interrupt-enable off, a match never sets the flag.
- R7: Writing 0 to status bit 0 clears the flag, and writing 1 has no effect. A match in the same cycle as a clear leaves the flag set. The irq output equals the flag.
- R8: The counter view at offset 0x14 returns the live count, both while the counter runs and while it is stopped. Writes to that offset have no effect.
- R9: A compare value written at offset 0x08 while the counter runs is used from the next tick. If the new value is below the count, no match happens until the counter wraps.
- R10: After reset every register reads zero and irq is low.
- R11: Compare values from 15 up to the full counter width produce matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, high while the status flag is set |

## Verification
The bench builds the timer with a 12-bit counter and a 3-bit divider field. The narrow counter puts a full wrap within about 4,100 cycles. This makes the free-running wrap and the below-count compare rewrite practical to observe. The 3-bit divider reaches the largest prescale of 256, so the top of the divider range is exercised. A compare of 4095 covers the full counter width, and a compare of 15 covers the small end the block must handle.

// File: rtl/intv_timer_pkg.sv
`timescale 1ns/1ps
package intv_timer_pkg;

   localparam int BUS_W  = 32;
   localparam int NREG   = 6;

   localparam logic [7:0] OFF_CTRL  = 8'h00;
   localparam logic [7:0] OFF_STAT  = 8'h04;
   localparam logic [7:0] OFF_CMP   = 8'h08;
   localparam logic [7:0] OFF_MATCH = 8'h0C;
   localparam logic [7:0] OFF_DIV   = 8'h10;
   localparam logic [7:0] OFF_CNT   = 8'h14;

   localparam int IX_CTRL  = 0;
   localparam int IX_STAT  = 1;
   localparam int IX_CMP   = 2;
   localparam int IX_MATCH = 3;
   localparam int IX_DIV   = 4;
   localparam int IX_CNT   = 5;

   localparam int MB_IRQ_EN = 0;
   localparam int MB_ZCLR   = 1;

   typedef struct packed {
      logic [1:0] mode;
      logic       div_en;
      logic       clr_en;
      logic       run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   function automatic logic [7:0] reg_offset(input int ix);
      case (ix)
         IX_CTRL:  return OFF_CTRL;
         IX_STAT:  return OFF_STAT;
         IX_CMP:   return OFF_CMP;
         IX_MATCH: return OFF_MATCH;
         IX_DIV:   return OFF_DIV;
         default:  return OFF_CNT;
      endcase
   endfunction

endpackage

// File: rtl/intv_timer_prescale.sv
`timescale 1ns/1ps
module intv_timer_prescale #(
   parameter int DIV_W         = 3,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             div_en,
   input  logic [DIV_W-1:0] div_sel,
   output logic             tick
);
   localparam int PRE_W = 1 << DIV_W;

   generate
      if (HAS_PRESCALER) begin : g_div
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] mask;

         // mask = 2^(n+1)-1; the shift wraps to all ones at the top setting
         always_comb mask = (PRE_W'(2) << div_sel) - PRE_W'(1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pre_q <= '0;
            else if (!run)   pre_q <= '0;
            else             pre_q <= pre_q + PRE_W'(1);
         end

         always_comb tick = run && (!div_en || ((pre_q & mask) == mask));
      end else begin : g_nodiv
         logic unused_cfg;
         always_comb unused_cfg = div_en ^ (^div_sel) ^ clk ^ rst_n;
         always_comb tick = run;
      end
   endgenerate

endmodule

// File: rtl/intv_timer_count.sv
`timescale 1ns/1ps
module intv_timer_count #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             stop_clr,
   input  logic             zclr_en,
   input  logic             irq_en,
   input  logic [CNT_W-1:0] cmp,
   input  logic             sts_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             at_cmp;
   logic             hit;
   logic             flag_q;

   always_comb begin
      at_cmp  = (cnt_q == cmp);
      cnt_nxt = (zclr_en && at_cmp) ? '0 : cnt_q + CNT_W'(1);
      hit     = tick && !stop_clr && (cnt_nxt == cmp);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (stop_clr) cnt_q <= '0;
      else if (tick)     cnt_q <= cnt_nxt;
   end

   // a new match beats a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (hit && irq_en)    flag_q <= 1'b1;
      else if (sts_clr)          flag_q <= 1'b0;
   end

   assign cnt  = cnt_q;
   assign flag = flag_q;

endmodule

// File: rtl/intv_timer_regs.sv
`timescale 1ns/1ps
module intv_timer_regs
   import intv_timer_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 24,
   parameter int DIV_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              flag,
   output logic              ctrl_run,
   output logic              div_en,
   output logic [DIV_W-1:0]  div_sel,
   output logic [CNT_W-1:0]  cmp,
   output logic              irq_en,
   output logic              zclr_en,
   output logic              stop_clr,
   output logic              sts_clr
);
   logic [NREG-1:0]  sel;
   logic [NREG-1:0]  wr;
   ctrl_t            ctrl_q;
   ctrl_t            ctrl_wd;
   logic [CNT_W-1:0] cmp_q;
   logic [1:0]       match_q;
   logic [DIV_W-1:0] div_q;
   logic             armed_q;
   logic [BUS_W-1:0] cnt_rd;
   logic [BUS_W-1:0] cmp_rd;

   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_dec
         localparam logic [7:0] OFF = reg_offset(gi);
         assign sel[gi] = (bus_addr == OFF[ADDR_W-1:0]);
         assign wr[gi]  = bus_we && sel[gi];
      end

      if (CNT_W < BUS_W) begin : g_pad
         assign cnt_rd = {{(BUS_W-CNT_W){1'b0}}, cnt};
         assign cmp_rd = {{(BUS_W-CNT_W){1'b0}}, cmp_q};
      end else begin : g_full
         assign cnt_rd = cnt;
         assign cmp_rd = cmp_q;
      end
   endgenerate

   assign ctrl_wd = ctrl_t'(bus_wdata[CTRL_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         cmp_q   <= '0;
         match_q <= '0;
         div_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (wr[IX_CTRL])  ctrl_q  <= ctrl_wd;
         if (wr[IX_CMP])   cmp_q   <= bus_wdata[CNT_W-1:0];
         if (wr[IX_MATCH]) match_q <= bus_wdata[1:0];
         if (wr[IX_DIV])   div_q   <= bus_wdata[DIV_W-1:0];
         if (wr[IX_CTRL] && ctrl_wd.run && ctrl_wd.clr_en) armed_q <= 1'b1;
      end
   end

   assign stop_clr = wr[IX_CTRL] && !ctrl_wd.run && ctrl_wd.clr_en && armed_q;
   assign sts_clr  = wr[IX_STAT] && !bus_wdata[0];

   always_comb begin
      bus_rdata = '0;
      unique case (1'b1)
         sel[IX_CTRL]:  bus_rdata = BUS_W'(ctrl_q);
         sel[IX_STAT]:  bus_rdata = BUS_W'(flag);
         sel[IX_CMP]:   bus_rdata = cmp_rd;
         sel[IX_MATCH]: bus_rdata = BUS_W'(match_q);
         sel[IX_DIV]:   bus_rdata = BUS_W'(div_q);
         sel[IX_CNT]:   bus_rdata = cnt_rd;
         default:       bus_rdata = '0;
      endcase
   end

   assign ctrl_run = ctrl_q.run;
   assign div_en   = ctrl_q.div_en;
   assign div_sel  = div_q;
   assign cmp      = cmp_q;
   assign irq_en   = match_q[MB_IRQ_EN];
   assign zclr_en  = match_q[MB_ZCLR];

endmodule

// File: rtl/intv_timer.sv
`timescale 1ns/1ps
module intv_timer
   import intv_timer_pkg::*;
#(
   parameter int ADDR_W        = 6,
   parameter int CNT_W         = 24,
   parameter int DIV_W         = 3,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
         $error("intv_timer: CNT_W must lie in 8..32");
      end
      if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
         $error("intv_timer: DIV_W must lie in 1..4");
      end
      if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
         $error("intv_timer: ADDR_W must lie in 5..8");
      end
   endgenerate

   logic             ctrl_run;
   logic             div_en;
   logic [DIV_W-1:0] div_sel;
   logic [CNT_W-1:0] cmp;
   logic             irq_en;
   logic             zclr_en;
   logic             stop_clr;
   logic             sts_clr;
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic             flag;

   intv_timer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .cnt      (cnt),
      .flag     (flag),
      .ctrl_run (ctrl_run),
      .div_en   (div_en),
      .div_sel  (div_sel),
      .cmp      (cmp),
      .irq_en   (irq_en),
      .zclr_en  (zclr_en),
      .stop_clr (stop_clr),
      .sts_clr  (sts_clr)
   );

   intv_timer_prescale #(.DIV_W(DIV_W), .HAS_PRESCALER(HAS_PRESCALER)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl_run),
      .div_en (div_en),
      .div_sel(div_sel),
      .tick   (tick)
   );

   intv_timer_count #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .stop_clr(stop_clr),
      .zclr_en (zclr_en),
      .irq_en  (irq_en),
      .cmp     (cmp),
      .sts_clr (sts_clr),
      .cnt     (cnt),
      .flag    (flag)
   );

   assign irq = flag;

endmodule

// File: rtl/intv_timer_chk.sv
`timescale 1ns/1ps
module intv_timer_chk #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             stop_clr,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp,
   input logic             zclr_en,
   input logic             irq_en,
   input logic             irq
);
   AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run); // R1

   AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !stop_clr) |=> $stable(cnt)); // R2

   AST_STOP_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_clr |=> (cnt == '0)); // R3

   AST_ZERO_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && zclr_en && (cnt == cmp) && !stop_clr) |=> (cnt == '0)); // R5

   AST_NO_FLAG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !irq) |=> !irq); // R6

   AST_RISE_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (cnt == $past(cmp))); // R6

endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (ctrl_run),
   .tick    (tick),
   .stop_clr(stop_clr),
   .cnt     (cnt),
   .cmp     (cmp),
   .zclr_en (zclr_en),
   .irq_en  (irq_en),
   .irq     (irq)
);

// File: tb/intv_timer_bench.sv
`timescale 1ns/1ps
module intv_timer_bench;
   localparam int CW = 12;
   localparam int AW = 6;

   localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_CMP = 6'h08,
                          A_MATCH = 6'h0C, A_DIV = 6'h10, A_CNT = 6'h14;
   localparam logic [31:0] C_RUN = 32'h1, C_CLR = 32'h2, C_DIV = 32'h4;
   localparam logic [31:0] M_IRQ = 32'h1, M_ZCLR = 32'h2;

   typedef struct packed {
      logic        div_en;
      logic [2:0]  div;
      logic [11:0] cmp;
      logic        zclr;
      logic [15:0] wait_n;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'd0, 12'd100,  1'b0, 16'd37},
      '{1'b1, 3'd0, 12'd100,  1'b0, 16'd40},
      '{1'b1, 3'd2, 12'd100,  1'b0, 16'd80},
      '{1'b0, 3'd0, 12'd15,   1'b1, 16'd40},
      '{1'b1, 3'd1, 12'd15,   1'b1, 16'd200},
      '{1'b0, 3'd0, 12'd4095, 1'b0, 16'd4100},
      '{1'b1, 3'd7, 12'd9,    1'b1, 16'd2600}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   intv_timer #(.ADDR_W(AW), .CNT_W(CW), .DIV_W(3)) u_intv_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // write lands on the next rising edge; returns 1 ns after it
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      logic [31:0] d;
      int ticks, expv, v0, gap;

      edges(3);
      rst_n = 1'b1;
      edges(1);

      // R10 reset state
      rd(A_CTRL, d);  chk("R10 ctrl", d, 0);
      rd(A_STAT, d);  chk("R10 status", d, 0);
      rd(A_CMP, d);   chk("R10 compare", d, 0);
      rd(A_MATCH, d); chk("R10 match", d, 0);
      rd(A_DIV, d);   chk("R10 divider", d, 0);
      rd(A_CNT, d);   chk("R10 counter", d, 0);
      chk("R10 irq", {31'b0, irq}, 0);

      // R4: not armed, so stop with clear-enable only freezes
      wr(A_CMP, 32'd4000);
      wr(A_CTRL, C_RUN);
      edges(10);
      wr(A_CTRL, C_CLR);
      rd(A_CNT, d); chk("R4 freeze before arming", d, 11);
      edges(5);
      rd(A_CNT, d); chk("R2 stays frozen", d, 11);
      wr(A_CNT, 32'd0);
      rd(A_CNT, d); chk("R8 counter write ignored", d, 11);
      rd(A_CTRL, d); chk("R2 ctrl readback", d, C_CLR);

      // R3: arm, run, then clearing stop
      wr(A_CTRL, C_RUN | C_CLR);
      edges(5);
      rd(A_CNT, d); chk("R8 live read while running", d, 16);
      wr(A_CTRL, C_CLR);
      rd(A_CNT, d); chk("R3 stop clears", d, 0);

      // vector table: R1 prescale, R5 zero-clear and wrap
      for (int i = 0; i < NV; i++) begin
         wr(A_CTRL, C_CLR);
         wr(A_CMP, 32'(VECS[i].cmp));
         wr(A_MATCH, VECS[i].zclr ? M_ZCLR : 32'd0);
         wr(A_DIV, 32'(VECS[i].div));
         wr(A_CTRL, C_RUN | C_CLR | (VECS[i].div_en ? C_DIV : 32'd0));
         edges(int'(VECS[i].wait_n));
         ticks = VECS[i].div_en ? int'(VECS[i].wait_n) / (2 << VECS[i].div)
                                : int'(VECS[i].wait_n);
         expv = VECS[i].zclr ? ticks % (int'(VECS[i].cmp) + 1) : ticks % 4096;
         rd(A_CNT, d); chk("R1 R5 vector", d, 32'(expv));
      end

      // R6 R11: flag on the edge the count reaches 15
      wr(A_CTRL, C_CLR);
      wr(A_CMP, 32'd15);
      wr(A_MATCH, M_IRQ | M_ZCLR);
      wr(A_DIV, 32'd0);
      wr(A_CTRL, C_RUN | C_CLR);
      edges(14);
      chk("R6 no irq before match", {31'b0, irq}, 0);
      edges(1);
      chk("R6 R11 irq at match of 15", {31'b0, irq}, 1);
      rd(A_STAT, d); chk("R6 status flag", d, 1);
      edges(15);
      wr(A_STAT, 32'd0);
      chk("R7 set wins over clear", {31'b0, irq}, 1);
      wr(A_STAT, 32'd1);
      chk("R7 write one keeps flag", {31'b0, irq}, 1);
      wr(A_STAT, 32'd0);
      chk("R7 clear by zero", {31'b0, irq}, 0);
      wr(A_STAT, 32'd1);
      chk("R7 write one does not set", {31'b0, irq}, 0);

      // R6 interrupt-enable off
      wr(A_CTRL, C_CLR);
      wr(A_STAT, 32'd0);
      wr(A_MATCH, M_ZCLR);
      wr(A_CTRL, C_RUN | C_CLR);
      edges(40);
      chk("R6 no flag when disabled", {31'b0, irq}, 0);
      rd(A_CNT, d); chk("R5 interval count", d, 8);

      // R9 compare rewritten below count waits for wrap
      wr(A_CTRL, C_CLR);
      wr(A_CMP, 32'd200);
      wr(A_MATCH, M_IRQ);
      wr(A_CTRL, C_RUN | C_CLR);
      edges(20);
      wr(A_CMP, 32'd5);
      rd(A_CNT, d); chk("R9 count at rewrite", d, 21);
      v0 = int'(d);
      gap = (5 - v0 + 4096) % 4096;
      edges(gap - 1);
      chk("R9 no match before wrap", {31'b0, irq}, 0);
      edges(1);
      chk("R9 match after wrap", {31'b0, irq}, 1);

      finish_up();
   end

endmodule